// File: doc/BRIEF.md
# Wrapping DMA Address Sequencer

This block produces the running addresses for one DMA channel on its two sides: the memory side and the peripheral side. Each side holds a base pointer and a sequencing word. The sequencing word carries a window-size code and a bus-width code. A single word-advance strobe moves both sides forward together, one 32-bit word (4 bytes) per strobe. When a side has a window configured, its address returns to the base after it has covered the whole window. With no window configured, it climbs linearly.

The two sides decode the same 3-bit window code into different window tables. The memory side counts in large blocks of 32 to 2048 words, while the peripheral side uses small ones of 1 to 64 words, which suits a FIFO register or a small register bank. A bus-width code outside the legal range on either side raises a configuration error. The error freezes both addresses until software loads a legal width.

Top module: `dma_addr_walker`

## Requirements
- R1: After reset both addresses are 0, the configuration error is low, both window codes mean "no wrap" and both width codes are 0.
- R2: A pointer write on a side loads that side's base, so that the side's address equals the written value on the next cycle, with the word offset cleared to zero.
- R3: Each accepted advance strobe raises the address on both sides by 4 bytes, unless the side wraps.
- R4: The memory-side window code sits at bits 18:16 of its sequencing word. Codes 1..7 select windows of 32, 64, 128, 256, 512, 1024 and 2048 words. After that many advances from the base, the address is back at the base.
- R5: The peripheral-side window code sits at bits 18:16 of its sequencing word. Codes 1..7 select windows of 1, 2, 4, 8, 16, 32 and 64 words. A 1-word window holds the address at the base.
- R6: Window code 0 on a side disables wrapping, and its address climbs linearly past every window size.
- R7: The width code sits at bits 30:28 of each sequencing word. Codes 0..4 are legal. Codes 5, 6 and 7 drive the configuration error high from the cycle after the write, and it stays high until both sides hold legal codes.
- R8: While the configuration error is high, advance strobes move neither address, but pointer writes still load.
- R9: A pointer write in the same cycle as an advance takes priority, and the side's address becomes the written base.
- R10: Without an advance strobe or a pointer write, an address holds its value. A sequencing write alone does not move the address.
- R11: Sequencing-word bits outside 30:28 and 18:16 have no effect on either address or on the error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_ptr_we | input | 1 | Memory-side base pointer write strobe |
| mem_ptr_in | input | AW | Memory-side base pointer value |
| mem_seq_we | input | 1 | Memory-side sequencing word write strobe |
| mem_seq_in | input | SEQ_W | Memory-side sequencing word (window 18:16, width 30:28) |
| per_ptr_we | input | 1 | Peripheral-side base pointer write strobe |
| per_ptr_in | input | AW | Peripheral-side base pointer value |
| per_seq_we | input | 1 | Peripheral-side sequencing word write strobe |
| per_seq_in | input | SEQ_W | Peripheral-side sequencing word (window 18:16, width 30:28) |
| adv | input | 1 | Word-advance strobe for both sides |
| mem_addr | output | AW | Current memory-side byte address |
| per_addr | output | AW | Current peripheral-side byte address |
| cfg_err | output | 1 | Reserved bus-width code present on either side |

## Verification
The bench walks each side through its smallest and largest windows and checks every address on the way.
- An off-by-one in the wrap compare shows up as one word too many, or too few, before the return to base. This is clearest with the 1-word peripheral window, which must never move.
- A design that swapped the two window tables would wrap the memory side after a handful of words.
- Linear mode is run past 2048 words. A design that treated code 0 as a small window would wrap there.
- The reserved width codes are tried one by one, with advances and pointer loads while the error is up. A design that ignored the error would drift, and one that also blocked loads would keep the old base.
- A pointer load in the same cycle as an advance checks that the load wins.

// File: rtl/dma_walk_pkg.sv
package dma_walk_pkg;
   localparam int SIDES          = 2;
   localparam int SIDE_MEM       = 0;
   localparam int SIDE_PER       = 1;
   localparam int FIELD_W        = 3;
   localparam int NCODES         = 1 << FIELD_W;
   localparam int WRAP_LSB       = 16;
   localparam int WIDTH_LSB      = 28;
   localparam int WIDTH_MAX_CODE = 4;
   localparam int WORD_BYTES_LOG2 = 2;

   // log2 of the window, in words, selected by code 1 on a side
   function automatic int min_win_log2(input int side);
      return (side == SIDE_MEM) ? 5 : 0;
   endfunction
endpackage

// File: rtl/dma_walk_seq.sv
module dma_walk_seq
   import dma_walk_pkg::*;
#(
   parameter int OFF_W    = 30,
   parameter int SEQ_W    = 32,
   parameter int MIN_LOG2 = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               seq_we,
   input  logic [SEQ_W-1:0]   seq_in,
   output logic [FIELD_W-1:0] wrap_code,
   output logic               wrap_on,
   output logic [OFF_W-1:0]   wrap_last,
   output logic               width_bad
);
   localparam int MAX_WIN_LOG2 = MIN_LOG2 + NCODES - 2;

   if (OFF_W < MAX_WIN_LOG2) begin : g_off_too_small
      $error("dma_walk_seq: offset counter narrower than the largest window");
   end
   if (SEQ_W < 31) begin : g_seq_too_small
      $error("dma_walk_seq: sequencing word lacks the width field");
   end

   logic [FIELD_W-1:0] code_q;
   logic [FIELD_W-1:0] width_q;
   logic [OFF_W-1:0]   last_tab [NCODES];

   // last offset inside each window, code 0 unused
   for (genvar k = 0; k < NCODES; k++) begin : g_tab
      if (k == 0) begin : g_nowrap
         assign last_tab[k] = '0;
      end else begin : g_win
         assign last_tab[k] = OFF_W'((64'd1 << (k - 1 + MIN_LOG2)) - 64'd1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         width_q <= '0;
      end else if (seq_we) begin
         code_q  <= seq_in[WRAP_LSB +: FIELD_W];
         width_q <= seq_in[WIDTH_LSB +: FIELD_W];
      end
   end

   logic unused_seq_bits;
   assign unused_seq_bits = ^{seq_in[SEQ_W-1:31], seq_in[27:19], seq_in[15:0]};

   assign wrap_code = code_q;
   assign wrap_on   = |code_q;
   assign wrap_last = last_tab[code_q];
   assign width_bad = width_q > FIELD_W'(WIDTH_MAX_CODE);
endmodule

// File: rtl/dma_walk_ctr.sv
module dma_walk_ctr
   import dma_walk_pkg::*;
#(
   parameter int AW    = 32,
   parameter int OFF_W = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_we,
   input  logic [AW-1:0]    ptr_in,
   input  logic             step,
   input  logic             wrap_on,
   input  logic [OFF_W-1:0] wrap_last,
   output logic [AW-1:0]    addr
);
   if (OFF_W + WORD_BYTES_LOG2 != AW) begin : g_bad_off
      $error("dma_walk_ctr: offset width must be the word part of the address");
   end

   logic [AW-1:0]    base_q;
   logic [OFF_W-1:0] off_q;
   logic             at_end;

   assign at_end = wrap_on && (off_q >= wrap_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         off_q  <= '0;
      end else if (ptr_we) begin
         base_q <= ptr_in;
         off_q  <= '0;
      end else if (step) begin
         off_q  <= at_end ? '0 : off_q + OFF_W'(1);
      end
   end

   assign addr = base_q + {off_q, {WORD_BYTES_LOG2{1'b0}}};
endmodule

// File: rtl/dma_addr_walker.sv
module dma_addr_walker
   import dma_walk_pkg::*;
#(
   parameter int AW    = 32,
   parameter int SEQ_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mem_ptr_we,
   input  logic [AW-1:0]    mem_ptr_in,
   input  logic             mem_seq_we,
   input  logic [SEQ_W-1:0] mem_seq_in,
   input  logic             per_ptr_we,
   input  logic [AW-1:0]    per_ptr_in,
   input  logic             per_seq_we,
   input  logic [SEQ_W-1:0] per_seq_in,
   input  logic             adv,
   output logic [AW-1:0]    mem_addr,
   output logic [AW-1:0]    per_addr,
   output logic             cfg_err
);
   localparam int OFF_W = AW - WORD_BYTES_LOG2;

   if (AW < 16) begin : g_aw_small
      $error("dma_addr_walker: address too narrow for the memory window table");
   end

   logic               ptr_we_v  [SIDES];
   logic [AW-1:0]      ptr_in_v  [SIDES];
   logic               seq_we_v  [SIDES];
   logic [SEQ_W-1:0]   seq_in_v  [SIDES];
   logic [AW-1:0]      addr_v    [SIDES];
   logic [FIELD_W-1:0] code_v    [SIDES];
   logic [SIDES-1:0]   width_bad;
   logic               step;
   logic [FIELD_W-1:0] mem_wrap_code;

   assign ptr_we_v[SIDE_MEM] = mem_ptr_we;
   assign ptr_in_v[SIDE_MEM] = mem_ptr_in;
   assign seq_we_v[SIDE_MEM] = mem_seq_we;
   assign seq_in_v[SIDE_MEM] = mem_seq_in;
   assign ptr_we_v[SIDE_PER] = per_ptr_we;
   assign ptr_in_v[SIDE_PER] = per_ptr_in;
   assign seq_we_v[SIDE_PER] = per_seq_we;
   assign seq_in_v[SIDE_PER] = per_seq_in;

   assign cfg_err = |width_bad;
   assign step    = adv & ~cfg_err;

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      logic             wrap_on;
      logic [OFF_W-1:0] wrap_last;

      dma_walk_seq #(
         .OFF_W    (OFF_W),
         .SEQ_W    (SEQ_W),
         .MIN_LOG2 (min_win_log2(s))
      ) u_seq (
         .clk       (clk),
         .rst_n     (rst_n),
         .seq_we    (seq_we_v[s]),
         .seq_in    (seq_in_v[s]),
         .wrap_code (code_v[s]),
         .wrap_on   (wrap_on),
         .wrap_last (wrap_last),
         .width_bad (width_bad[s])
      );

      dma_walk_ctr #(
         .AW    (AW),
         .OFF_W (OFF_W)
      ) u_ctr (
         .clk       (clk),
         .rst_n     (rst_n),
         .ptr_we    (ptr_we_v[s]),
         .ptr_in    (ptr_in_v[s]),
         .step      (step),
         .wrap_on   (wrap_on),
         .wrap_last (wrap_last),
         .addr      (addr_v[s])
      );
   end

   logic [FIELD_W-1:0] unused_per_code;
   assign unused_per_code = code_v[SIDE_PER];

   assign mem_wrap_code = code_v[SIDE_MEM];
   assign mem_addr      = addr_v[SIDE_MEM];
   assign per_addr      = addr_v[SIDE_PER];
endmodule

// File: rtl/dma_walk_chk.sv
module dma_walk_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          adv,
   input logic          cfg_err,
   input logic          mem_ptr_we,
   input logic [AW-1:0] mem_ptr_in,
   input logic          per_ptr_we,
   input logic [AW-1:0] per_ptr_in,
   input logic          mem_seq_we,
   input logic [2:0]    mem_width_in,
   input logic          per_seq_we,
   input logic [2:0]    per_width_in,
   input logic [2:0]    mem_wrap_code,
   input logic [AW-1:0] mem_addr,
   input logic [AW-1:0] per_addr
);
   assert_mem_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ptr_we |=> mem_addr == $past(mem_ptr_in));

   assert_per_ptr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (per_ptr_we && adv) |=> per_addr == $past(per_ptr_in));

   assert_mem_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !cfg_err && !mem_ptr_we && mem_wrap_code == 3'd0)
      |=> mem_addr == $past(mem_addr) + AW'(4));

   assert_reserved_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_seq_we && mem_width_in > 3'd4) || (per_seq_we && per_width_in > 3'd4))
      |=> cfg_err);

   assert_err_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !mem_ptr_we && !per_ptr_we)
      |=> ($stable(mem_addr) && $stable(per_addr)));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !mem_ptr_we && !per_ptr_we)
      |=> ($stable(mem_addr) && $stable(per_addr)));
endmodule

bind dma_addr_walker dma_walk_chk #(.AW(AW)) u_walk_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .adv           (adv),
   .cfg_err       (cfg_err),
   .mem_ptr_we    (mem_ptr_we),
   .mem_ptr_in    (mem_ptr_in),
   .per_ptr_we    (per_ptr_we),
   .per_ptr_in    (per_ptr_in),
   .mem_seq_we    (mem_seq_we),
   .mem_width_in  (mem_seq_in[30:28]),
   .per_seq_we    (per_seq_we),
   .per_width_in  (per_seq_in[30:28]),
   .mem_wrap_code (mem_wrap_code),
   .mem_addr      (mem_addr),
   .per_addr      (per_addr)
);

// File: tb/test_dma_addr_walker.sv
module test_dma_addr_walker;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int SEQ_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic             pw [2];
   logic [AW-1:0]    pd [2];
   logic             sw [2];
   logic [SEQ_W-1:0] sd [2];
   logic             adv;
   logic [AW-1:0]    mem_addr, per_addr;
   logic             cfg_err;

   dma_addr_walker #(.AW(AW), .SEQ_W(SEQ_W)) i_dma_addr_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .mem_ptr_we (pw[0]),
      .mem_ptr_in (pd[0]),
      .mem_seq_we (sw[0]),
      .mem_seq_in (sd[0]),
      .per_ptr_we (pw[1]),
      .per_ptr_in (pd[1]),
      .per_seq_we (sw[1]),
      .per_seq_in (sd[1]),
      .adv        (adv),
      .mem_addr   (mem_addr),
      .per_addr   (per_addr),
      .cfg_err    (cfg_err)
   );

   // reference state
   logic [31:0] m_base [2];
   logic [31:0] m_off  [2];
   logic [2:0]  m_code [2];
   logic [2:0]  m_wid  [2];

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   function automatic logic [31:0] win_words(input int side, input logic [2:0] code);
      if (side == 0) return 32'd16 << code;
      return 32'd1 << (code - 3'd1);
   endfunction

   function automatic logic [31:0] seq_word(input logic [2:0] wid, input logic [2:0] code,
                                            input logic [31:0] junk);
      logic [31:0] w;
      w = junk & ~32'h7007_0000;
      w[30:28] = wid;
      w[18:16] = code;
      return w;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic clear_in();
      for (int s = 0; s < 2; s++) begin
         pw[s] = 1'b0; pd[s] = '0; sw[s] = 1'b0; sd[s] = '0;
      end
      adv = 1'b0;
   endtask

   task automatic compare(input string tag);
      logic err_exp;
      err_exp = (m_wid[0] > 3'd4) || (m_wid[1] > 3'd4);
      chk(tag, "mem_addr", mem_addr, m_base[0] + (m_off[0] << 2));
      chk(tag, "per_addr", per_addr, m_base[1] + (m_off[1] << 2));
      chk(tag, "cfg_err", {31'd0, cfg_err}, {31'd0, err_exp});
   endtask

   // inputs are set while clk is low; one edge, then model update and compare
   task automatic tick(input string tag);
      logic bad;
      @(posedge clk);
      bad = (m_wid[0] > 3'd4) || (m_wid[1] > 3'd4);
      for (int s = 0; s < 2; s++) begin
         if (pw[s]) begin
            m_base[s] = pd[s];
            m_off[s]  = '0;
         end else if (adv && !bad) begin
            if (m_code[s] != 3'd0 && m_off[s] >= win_words(s, m_code[s]) - 32'd1)
               m_off[s] = '0;
            else
               m_off[s] = m_off[s] + 32'd1;
         end
         if (sw[s]) begin
            m_code[s] = sd[s][18:16];
            m_wid[s]  = sd[s][30:28];
         end
      end
      #(CLK_PERIOD / 4);
      compare(tag);
      @(negedge clk);
      clear_in();
   endtask

   task automatic load_ptr(input logic [31:0] mb, input logic [31:0] pb, input string tag);
      pw[0] = 1'b1; pd[0] = mb; pw[1] = 1'b1; pd[1] = pb;
      tick(tag);
   endtask

   task automatic load_seq(input int side, input logic [2:0] wid, input logic [2:0] code,
                           input string tag);
      sw[side] = 1'b1;
      sd[side] = seq_word(wid, code, $urandom);
      tick(tag);
   endtask

   task automatic advance(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         adv = 1'b1;
         tick(tag);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      clear_in();
      for (int s = 0; s < 2; s++) begin
         m_base[s] = '0; m_off[s] = '0; m_code[s] = '0; m_wid[s] = '0;
      end
      repeat (3) @(negedge clk);
      #(CLK_PERIOD / 4);
      compare("R1");
      @(negedge clk);
      rst_n = 1'b1;
      tick("R1");

      // R3: plain linear stepping from a loaded base
      load_ptr(32'h1000_0000, 32'h7000_0100, "R2");
      advance(3, "R3");

      // R4/R5 with junk in unused sequencing bits (R11)
      load_seq(0, 3'd2, 3'd1, "R11");
      load_seq(1, 3'd1, 3'd3, "R11");
      load_ptr(32'h2000_0040, 32'h7000_0200, "R2");
      advance(70, "R4 R5");

      load_seq(1, 3'd0, 3'd1, "R5");
      advance(5, "R5");
      load_seq(1, 3'd4, 3'd7, "R5");
      advance(130, "R5");

      load_seq(0, 3'd3, 3'd7, "R4");
      load_ptr(32'h3000_0000, 32'h7000_0300, "R2");
      advance(2049, "R4");
      load_seq(0, 3'd3, 3'd6, "R4");
      load_ptr(32'h3100_0000, 32'h7000_0300, "R2");
      advance(1025, "R4");

      // R6: no wrap past the largest window
      load_seq(0, 3'd2, 3'd0, "R6");
      load_seq(1, 3'd2, 3'd0, "R6");
      load_ptr(32'h4000_0000, 32'h7000_0400, "R2");
      advance(2100, "R6");

      // R10: sequencing write alone does not move anything
      advance(7, "R10");
      load_seq(0, 3'd2, 3'd2, "R10");
      load_seq(1, 3'd2, 3'd4, "R10");
      tick("R10");
      tick("R10");

      // R7/R8: reserved width codes
      for (int c = 5; c < 8; c++) begin
         load_seq(1, 3'(c), 3'd4, "R7");
         advance(3, "R8");
         pw[0] = 1'b1; pd[0] = 32'h5000_0000 + 32'(c); adv = 1'b1;
         tick("R8");
         load_seq(1, 3'd4, 3'd4, "R7");
         advance(2, "R3");
      end
      load_seq(0, 3'd7, 3'd2, "R7");
      advance(2, "R8");
      load_seq(0, 3'd4, 3'd2, "R7");
      advance(2, "R3");

      // R9: load wins over a simultaneous advance
      pw[0] = 1'b1; pd[0] = 32'h6000_0000; pw[1] = 1'b1; pd[1] = 32'h7000_0600; adv = 1'b1;
      tick("R9");
      advance(1, "R3");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         adv = ($urandom_range(99) < 70);
         for (int s = 0; s < 2; s++) begin
            if ($urandom_range(99) < 2) begin
               pw[s] = 1'b1; pd[s] = $urandom;
            end
            if ($urandom_range(99) < 3) begin
               sw[s] = 1'b1;
               sd[s] = seq_word(($urandom_range(9) == 0) ? 3'($urandom_range(7, 5))
                                                         : 3'($urandom_range(4)),
                                3'($urandom_range(7)), $urandom);
            end
         end
         tick("R4 R5 R8 R9");
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule